// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds the time of day and the calendar date: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Each pulse on the one-second strobe moves the whole set forward by one second. Carries ripple from seconds up to the year. Month lengths follow the Gregorian calendar, including the leap-year rule.

Values are kept internally as plain binary counts. They are converted on the way out, and on the way in, to the register format that software sees. Two mode inputs select that format. One picks packed BCD or straight binary. The other picks 24-hour or 12-hour presentation; in 12-hour form the top bit of the hour field flags the afternoon. A parallel load writes all seven fields at once in the current register format. The block converts them back to binary. Because only the presentation depends on the mode inputs, changing a mode never disturbs the stored time.

The parameter `BASE_YEAR` gives the calendar year that a year field of zero stands for. The leap-year rule is applied to `BASE_YEAR` plus the stored two-digit offset.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the stored time is 00:00:00, weekday 1, day 1, month 1, year offset 0.
- R2: On a strobe, seconds count up. Seconds wrap at 60 and carry into minutes. Minutes wrap at 60 and carry into hours. Hours wrap at 24 and carry into the date. Without a strobe or a load, no field changes.
- R3: On a day carry, a weekday of 1 to 6 increments and a weekday of 7 returns to 1. Any value outside 1..7 becomes 1.
- R4: On a day carry, the day of month increments. When the new value would exceed the month length, the day becomes 1 and the month advances. A month of 12 or more returns to 1 and increments the year. A month outside 1..12 is given a length of 31. A day of 0 becomes 1 without a month change.
- R5: February has 29 days when `BASE_YEAR` + year offset is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise February has 28 days.
- R6: The year offset stays in 0..99 and wraps from 99 to 0.
- R7: With `bin_mode`=1 each output field is the binary value. With `bin_mode`=0 each field is packed BCD: tens digit in bits 7:4, units digit in bits 3:0. A mode change alters the outputs at once and leaves the stored time untouched.
- R8: With `hr24`=0, `q_hour` bits 6:0 hold hour mod 12 in the selected format, and bit 7 is set when the hour is 12 or more. With `hr24`=1, `q_hour` is the hour 0..23.
- R9: A load decodes each field from the current format. With `hr24`=0, bits 6:0 of the hour field are decoded and bit 7 adds 12. The loaded year is stored modulo 100. The weekday, day and month are stored as given.
- R10: When a load and a strobe arrive in the same cycle, the load wins and no increment happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance strobe |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag in bit 7 |
| ld_en | input | 1 | Load all fields from the ld_* inputs |
| ld_sec | input | 8 | Seconds to load (register format) |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_wday | input | 8 | Weekday to load (1..7) |
| ld_mday | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load (1..12) |
| ld_year | input | 8 | Two-digit year to load |
| q_sec | output | 8 | Seconds in register format |
| q_min | output | 8 | Minutes |
| q_hour | output | 8 | Hours |
| q_wday | output | 8 | Weekday |
| q_mday | output | 8 | Day of month |
| q_mon | output | 8 | Month |
| q_year | output | 8 | Two-digit year |

## Verification
Directed loads place the counter one second before each kind of rollover: end of a 30-day month, end of the year, February in a leap year and in a common year, a weekday of 7, an out-of-range month, and a day of 0. These cases separate the carry paths from each other and test the month-length table. Mode inputs are then flipped with no strobe. This shows that only the presentation changes, and it separates BCD from binary encoding and the PM flag from the hour value. A loaded 12-hour afternoon value and a load that coincides with a strobe cover the decode path and its priority. Seeded random loads in random modes, each followed by a few strobes, compare every field against a bench model of the calendar.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       ld_en,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_mday,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic [7:0] q_sec,
  output logic [7:0] q_min,
  output logic [7:0] q_hour,
  output logic [7:0] q_wday,
  output logic [7:0] q_mday,
  output logic [7:0] q_mon,
  output logic [7:0] q_year
);

  logic [7:0] sec_r, min_r, hour_r, wday_r, mday_r, mon_r, year_r;

  function automatic logic [7:0] to_reg(input logic [7:0] v, input logic bin);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bin ? v : ((tens << 4) | ones);
  endfunction

  function automatic logic [7:0] from_reg(input logic [7:0] r, input logic bin);
    logic [7:0] tens;
    tens = {4'd0, r[7:4]};
    return bin ? r : (tens * 8'd10 + {4'd0, r[3:0]});
  endfunction

  function automatic logic [8:0] month_len(input logic [7:0] m, input logic leap);
    case (m)
      8'd4, 8'd6, 8'd9, 8'd11: return 9'd30;
      8'd2:                    return leap ? 9'd29 : 9'd28;
      default:                 return 9'd31;
    endcase
  endfunction

  int unsigned full_year;
  logic        leap;
  logic [8:0]  mday_inc;
  logic        sec_c, min_c, hour_c, mday_c, mon_c;
  logic [7:0]  hour_ld;

  assign full_year = BASE_YEAR + int'(year_r);
  assign leap      = (full_year % 4 == 0) && ((full_year % 100 != 0) || (full_year % 400 == 0));
  assign mday_inc  = {1'b0, mday_r} + 9'd1;
  assign sec_c     = sec_r  >= 8'd59;
  assign min_c     = min_r  >= 8'd59;
  assign hour_c    = hour_r >= 8'd23;
  assign mday_c    = mday_inc > month_len(mon_r, leap);
  assign mon_c     = mon_r  >= 8'd12;
  assign hour_ld   = from_reg({1'b0, ld_hour[6:0]}, bin_mode) + ((!hr24 && ld_hour[7]) ? 8'd12 : 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_r  <= 8'd0;
      min_r  <= 8'd0;
      hour_r <= 8'd0;
      wday_r <= 8'd1;
      mday_r <= 8'd1;
      mon_r  <= 8'd1;
      year_r <= 8'd0;
    end else if (ld_en) begin
      sec_r  <= from_reg(ld_sec, bin_mode);
      min_r  <= from_reg(ld_min, bin_mode);
      hour_r <= hour_ld;
      wday_r <= from_reg(ld_wday, bin_mode);
      mday_r <= from_reg(ld_mday, bin_mode);
      mon_r  <= from_reg(ld_mon, bin_mode);
      year_r <= from_reg(ld_year, bin_mode) % 8'd100;
    end else if (tick) begin
      sec_r <= sec_c ? 8'd0 : sec_r + 8'd1;
      if (sec_c) begin
        min_r <= min_c ? 8'd0 : min_r + 8'd1;
        if (min_c) begin
          hour_r <= hour_c ? 8'd0 : hour_r + 8'd1;
          if (hour_c) begin
            wday_r <= (wday_r >= 8'd1 && wday_r <= 8'd6) ? wday_r + 8'd1 : 8'd1;
            if (mday_c) begin
              mday_r <= 8'd1;
              if (mon_c) begin
                mon_r  <= 8'd1;
                year_r <= (year_r >= 8'd99) ? 8'd0 : year_r + 8'd1;
              end else begin
                mon_r <= mon_r + 8'd1;
              end
            end else begin
              mday_r <= mday_inc[7:0];
            end
          end
        end
      end
    end
  end

  assign q_sec  = to_reg(sec_r,  bin_mode);
  assign q_min  = to_reg(min_r,  bin_mode);
  assign q_hour = hr24 ? to_reg(hour_r, bin_mode)
                       : (to_reg(hour_r % 8'd12, bin_mode) | ((hour_r >= 8'd12) ? 8'h80 : 8'h00));
  assign q_wday = to_reg(wday_r, bin_mode);
  assign q_mday = to_reg(mday_r, bin_mode);
  assign q_mon  = to_reg(mon_r,  bin_mode);
  assign q_year = to_reg(year_r, bin_mode);

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ld_en,
  input logic       hr24,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] wday,
  input logic [7:0] mday,
  input logic [7:0] mon,
  input logic [7:0] year,
  input logic [7:0] q_hour
);

  logic day_roll;
  assign day_roll = tick && !ld_en && sec == 8'd59 && min == 8'd59 && hour == 8'd23;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_en && sec == 8'd59) |=> (sec == 8'd0)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(wday)
                           && $stable(mday) && $stable(mon) && $stable(year))); // R2

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && wday == 8'd7) |=> (wday == 8'd1)); // R3

  AST_FEB29_END: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && mon == 8'd2 && mday == 8'd29) |=> (mday == 8'd1 && mon == 8'd3)); // R5

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && mon == 8'd12 && mday == 8'd31 && year == 8'd99) |=> (year == 8'd0 && mon == 8'd1)); // R6

  AST_YEAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    year < 8'd100); // R6

  AST_PM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!hr24 && hour >= 8'd12 && hour < 8'd24) |-> q_hour[7]); // R8

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en), .hr24(hr24),
  .sec(sec_r), .min(min_r), .hour(hour_r), .wday(wday_r), .mday(mday_r),
  .mon(mon_r), .year(year_r), .q_hour(q_hour)
);

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
  localparam int BASE = 2000;

  logic clk = 0, rst_n = 0, tick = 0, bin_mode = 0, hr24 = 1, ld_en = 0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0, ld_mday = 0, ld_mon = 0, ld_year = 0;
  logic [7:0] q_sec, q_min, q_hour, q_wday, q_mday, q_mon, q_year;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  int s, mi, h, w, d, mo, y;

  always #5 clk = ~clk;

  rtc_calendar_core #(.BASE_YEAR(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode), .hr24(hr24), .ld_en(ld_en),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday), .ld_mday(ld_mday),
    .ld_mon(ld_mon), .ld_year(ld_year),
    .q_sec(q_sec), .q_min(q_min), .q_hour(q_hour), .q_wday(q_wday), .q_mday(q_mday),
    .q_mon(q_mon), .q_year(q_year));

  function automatic logic [7:0] enc(int v, bit b);
    int r;
    r = b ? v : (((v / 10) << 4) | (v % 10));
    return 8'(r & 255);
  endfunction

  function automatic int dec(logic [7:0] r, bit b);
    return b ? int'(r) : int'(r[7:4]) * 10 + int'(r[3:0]);
  endfunction

  function automatic int dim(int m, int yy);
    int fy;
    fy = BASE + yy;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    if (m == 2) return ((fy % 4 == 0) && ((fy % 100 != 0) || (fy % 400 == 0))) ? 29 : 28;
    return 31;
  endfunction

  function automatic logic [7:0] enc_hour(int hv, bit b, bit t24);
    if (t24) return enc(hv, b);
    return enc(hv % 12, b) | ((hv >= 12) ? 8'h80 : 8'h00);
  endfunction

  task automatic model_tick();
    if (s < 59) begin s++; return; end
    s = 0;
    if (mi < 59) begin mi++; return; end
    mi = 0;
    if (h < 23) begin h++; return; end
    h = 0;
    w = (w >= 1 && w <= 6) ? w + 1 : 1;
    if (d + 1 > dim(mo, y)) begin
      d = 1;
      if (mo >= 12) begin mo = 1; y = (y >= 99) ? 0 : y + 1; end
      else mo = mo + 1;
    end else d = d + 1;
  endtask

  task automatic model_load();
    s  = dec(ld_sec, bin_mode);
    mi = dec(ld_min, bin_mode);
    h  = dec({1'b0, ld_hour[6:0]}, bin_mode) + ((!hr24 && ld_hour[7]) ? 12 : 0);
    w  = dec(ld_wday, bin_mode);
    d  = dec(ld_mday, bin_mode);
    mo = dec(ld_mon, bin_mode);
    y  = dec(ld_year, bin_mode) % 100;
  endtask

  task automatic do_cycle(bit t, bit l);
    tick = t; ld_en = l;
    @(posedge clk);
    if (l) model_load(); else if (t) model_tick();
    @(negedge clk);
    tick = 0; ld_en = 0;
  endtask

  task automatic check(string req);
    logic [7:0] e [7];
    logic [7:0] a [7];
    bit bad;
    e[0] = enc(s, bin_mode); e[1] = enc(mi, bin_mode); e[2] = enc_hour(h, bin_mode, hr24);
    e[3] = enc(w, bin_mode); e[4] = enc(d, bin_mode); e[5] = enc(mo, bin_mode); e[6] = enc(y, bin_mode);
    a[0] = q_sec; a[1] = q_min; a[2] = q_hour; a[3] = q_wday; a[4] = q_mday; a[5] = q_mon; a[6] = q_year;
    bad = 0;
    foreach (e[i]) if (a[i] !== e[i]) bad = 1;
    n_run++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got %h %h %h %h %h %h %h expected %h %h %h %h %h %h %h", req,
               a[0], a[1], a[2], a[3], a[4], a[5], a[6], e[0], e[1], e[2], e[3], e[4], e[5], e[6]);
    end
  endtask

  task automatic load_time(int ss, int mm, int hh, int ww, int dd, int mn, int yy);
    ld_sec = enc(ss, bin_mode); ld_min = enc(mm, bin_mode); ld_hour = enc_hour(hh, bin_mode, hr24);
    ld_wday = enc(ww, bin_mode); ld_mday = enc(dd, bin_mode); ld_mon = enc(mn, bin_mode);
    ld_year = enc(yy, bin_mode);
    do_cycle(0, 1);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    s = 0; mi = 0; h = 0; w = 1; d = 1; mo = 1; y = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state");

    do_cycle(0, 0); do_cycle(0, 0);
    check("R2 idle hold");
    do_cycle(1, 0);
    check("R2 plain second");

    load_time(59, 59, 23, 7, 31, 12, 99);
    check("R9 BCD 24h load");
    do_cycle(1, 0);
    check("R6 R4 R3 year end rollover");

    load_time(59, 59, 23, 2, 28, 2, 0);
    do_cycle(1, 0);
    check("R5 leap Feb 28 to 29");
    load_time(59, 59, 23, 2, 29, 2, 0);
    do_cycle(1, 0);
    check("R5 leap Feb 29 to Mar 1");
    load_time(59, 59, 23, 2, 28, 2, 1);
    do_cycle(1, 0);
    check("R5 common Feb 28 to Mar 1");

    load_time(59, 59, 23, 3, 30, 4, 5);
    do_cycle(1, 0);
    check("R4 30-day month end");
    load_time(59, 59, 23, 0, 31, 13, 7);
    do_cycle(1, 0);
    check("R4 R3 out-of-range month and weekday");
    load_time(59, 59, 23, 4, 0, 6, 7);
    do_cycle(1, 0);
    check("R4 day zero forced to 1");

    load_time(5, 30, 13, 2, 9, 9, 42);
    bin_mode = 1; #1;
    check("R7 switch to binary");
    hr24 = 0; #1;
    check("R8 12h binary PM");
    bin_mode = 0; #1;
    check("R7 R8 12h BCD PM");

    ld_sec = 8'h58; ld_min = 8'h59; ld_hour = 8'h91; ld_wday = 8'h05;
    ld_mday = 8'h15; ld_mon = 8'h08; ld_year = 8'h21;
    do_cycle(0, 1);
    check("R9 12h PM load");
    do_cycle(1, 0); do_cycle(1, 0);
    check("R8 R2 12h midnight rollover");

    hr24 = 1;
    ld_sec = 8'h10; ld_min = 8'h20; ld_hour = 8'h03; ld_wday = 8'h01;
    ld_mday = 8'h02; ld_mon = 8'h03; ld_year = 8'h04;
    do_cycle(1, 1);
    check("R10 load beats tick");

    bin_mode = 1;
    ld_year = 8'd150; ld_sec = 8'd0; ld_min = 8'd0; ld_hour = 8'd0;
    ld_wday = 8'd1; ld_mday = 8'd1; ld_mon = 8'd1;
    do_cycle(0, 1);
    check("R9 R6 year stored mod 100");

    for (int it = 0; it < 300; it++) begin
      int ss, mm, hh, mn, yy, dd;
      bin_mode = 1'($urandom_range(1));
      hr24 = 1'($urandom_range(1));
      ss = ($urandom_range(3) == 0) ? 59 : int'($urandom_range(59));
      mm = ($urandom_range(2) == 0) ? 59 : int'($urandom_range(59));
      hh = ($urandom_range(2) == 0) ? 23 : int'($urandom_range(23));
      mn = int'($urandom_range(12, 1));
      yy = int'($urandom_range(99));
      dd = ($urandom_range(1) == 0) ? dim(mn, yy) : int'($urandom_range(dim(mn, yy), 1));
      load_time(ss, mm, hh, int'($urandom_range(7, 1)), dd, mn, yy);
      check("R9 random load");
      for (int k = 0; k < int'($urandom_range(4, 1)); k++) begin
        do_cycle(1, 0);
        check("R2 R4 random advance");
      end
      bin_mode = ~bin_mode; #1;
      check("R7 random mode flip");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule